// File: doc/BRIEF.md
# Single-Instruction Step Controller

This block lets a host walk a 16-bit processor through its program one instruction at a time. It works through the processor's existing bus-hold request line and adds no halt logic inside the core. When stepping is switched on, the hold request stays high, so the processor parks at its next instruction boundary and raises its hold acknowledge. A step command drops the hold request for exactly one clock. The processor samples the request only at an instruction boundary, so it fetches and runs exactly one instruction and then parks again.

On every opcode fetch the block captures the opcode, program counter and status word into a 64-bit snapshot. The snapshot also holds a step counter, so the host can build an instruction trace. The host polls a "stopped" flag before it reads the snapshot. A mask can keep video interrupt requests away from the processor while stepping, because slow stepping would otherwise leave those interrupts pending all the time. When stepping is off, the hold request simply follows an external DMA request. A small register port with an address, a write strobe and combinational read data serves as the host link.

Top module: `step_dbg_ctrl`

## Requirements
- R1: After reset, the control word reads 0 and all four snapshot words read 0.
- R2: While step mode is off, `cpu_hold_req` equals `ext_dma_req` in every cycle.
- R3: While step mode is on and no release is in progress, `cpu_hold_req` is 1 and the processor makes no fetch.
- R4: The host sets step mode on (control bit 0 = 1) and writes the trigger (control bit 1 = 1) together. This write is accepted only if step mode was already on, `cpu_hold_ack` is 1 and no earlier step is still pending. An accepted trigger drives `cpu_hold_req` low for exactly the one cycle after the write. A pending flag is then set, which reads as control bit 1. The trigger itself is not stored, and the pending flag clears on the next fetch.
- R5: One accepted trigger lets the processor make exactly one opcode fetch before it holds again.
- R6: A trigger write is ignored while a step is pending or while `cpu_hold_ack` is 0. Two back-to-back trigger writes, or a trigger during execution, still give exactly one fetch.
- R7: Each cycle with `cpu_fetch` high captures the snapshot. Address 7 reads the opcode, 6 the program counter, 5 the status word and 4 the step counter. Addresses 1 to 3 read 0.
- R8: The step counter adds one on each fetch made while step mode is on. It clears to 0 when a write turns step mode on from off. If that write lands in a fetch cycle, the fetch is captured with count 0 and is not counted. Rewriting step mode as on while it is already on keeps the count.
- R9: Control bit 3 reads 1 ("stopped") exactly when step mode is on and `cpu_hold_ack` is 1.
- R10: `cpu_irq_out` follows `vid_irq_in`, except that it is 0 while step mode and the interrupt mask (control bit 2) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 3 | Host register address |
| reg_wr | input | 1 | Host write strobe; only address 0 is writable |
| reg_wdata | input | 3 | Control write data: bit 0 step mode, bit 1 trigger, bit 2 interrupt mask |
| reg_rdata | output | 16 | Host read data for `reg_addr` |
| ext_dma_req | input | 1 | External bus-hold request, passed through when stepping is off |
| cpu_hold_req | output | 1 | Bus-hold request to the processor |
| cpu_hold_ack | input | 1 | Processor parked at an instruction boundary |
| cpu_fetch | input | 1 | Processor opcode-fetch strobe |
| cpu_opcode | input | 16 | Opcode being fetched |
| cpu_pc | input | 16 | Program counter of the fetched instruction |
| cpu_st | input | 16 | Processor status word |
| vid_irq_in | input | 1 | Video interrupt request |
| cpu_irq_out | output | 1 | Interrupt request delivered to the processor |

## Verification
Two events can fall in the same cycle: a host write that turns step mode on, and an opcode fetch that would otherwise update the counter. The bench lets a stub processor run freely with the hold request released. It waits until it sees a fetch strobe and drives the enabling write in that same cycle. The run passes only if the snapshot holds that instruction's opcode, PC and status with a count of 0, and the processor then parks without another fetch. The next step must then read a count of 1.

// File: rtl/step_dbg_pkg.sv
`timescale 1ns/1ps
package step_dbg_pkg;
  // control word bits (write)
  localparam int BIT_STEP  = 0;
  localparam int BIT_TRIG  = 1;
  localparam int BIT_MASK  = 2;
  localparam int CTL_WBITS = 3;
  // control word bits (read)
  localparam int BIT_BUSY  = 1;
  localparam int BIT_STOP  = 3;
  // address map
  localparam int ADDR_CTL   = 0;
  localparam int SNAP_BASE  = 4;
  localparam int SNAP_WORDS = 4;
endpackage

// File: rtl/step_ctrl_regs.sv
`timescale 1ns/1ps
module step_ctrl_regs
  import step_dbg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_wr,
  input  logic [CTL_WBITS-1:0] ctl_wdata,
  input  logic                 hold_ack,
  input  logic                 cpu_fetch,
  output logic                 step_en,
  output logic                 irq_mask,
  output logic                 busy,
  output logic                 rel_pulse,
  output logic                 enable_set,
  output logic                 trig_req
);
  logic trig_ok;

  assign enable_set = ctl_wr & ctl_wdata[BIT_STEP] & ~step_en;
  assign trig_req   = ctl_wr & ctl_wdata[BIT_TRIG];
  assign trig_ok    = trig_req & ctl_wdata[BIT_STEP] & step_en & hold_ack
                      & ~busy & ~rel_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_en   <= 1'b0;
      irq_mask  <= 1'b0;
      busy      <= 1'b0;
      rel_pulse <= 1'b0;
    end else begin
      if (ctl_wr) begin
        step_en  <= ctl_wdata[BIT_STEP];
        irq_mask <= ctl_wdata[BIT_MASK];
      end
      rel_pulse <= trig_ok;
      if (trig_ok)
        busy <= 1'b1;
      else if (cpu_fetch || (ctl_wr && !ctl_wdata[BIT_STEP]))
        busy <= 1'b0;
    end
  end
endmodule

// File: rtl/step_snapshot.sv
`timescale 1ns/1ps
module step_snapshot #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_fetch,
  input  logic [DW-1:0]   cpu_opcode,
  input  logic [DW-1:0]   cpu_pc,
  input  logic [DW-1:0]   cpu_st,
  input  logic            step_en,
  input  logic            enable_set,
  output logic [DW-1:0]   count,
  output logic [4*DW-1:0] snap
);
  logic [DW-1:0] cnt_nx;

  function automatic logic [DW-1:0] next_count(
    input logic [DW-1:0] c, input logic fetch, input logic en, input logic clr);
    if (clr)             return '0;
    else if (fetch & en) return c + 1'b1;
    else                 return c;
  endfunction

  function automatic logic [4*DW-1:0] pack_snap(
    input logic [DW-1:0] op, input logic [DW-1:0] pc,
    input logic [DW-1:0] st, input logic [DW-1:0] c);
    return {op, pc, st, c};
  endfunction

  assign cnt_nx = next_count(count, cpu_fetch, step_en, enable_set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      snap  <= '0;
    end else begin
      count <= cnt_nx;
      if (cpu_fetch)
        snap <= pack_snap(cpu_opcode, cpu_pc, cpu_st, cnt_nx);
    end
  end
endmodule

// File: rtl/step_read_mux.sv
`timescale 1ns/1ps
module step_read_mux
  import step_dbg_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic [AW-1:0]   addr,
  input  logic            step_en,
  input  logic            busy,
  input  logic            irq_mask,
  input  logic            stopped,
  input  logic [4*DW-1:0] snap,
  output logic [DW-1:0]   rdata
);
  localparam int IDXW = $clog2(SNAP_WORDS);

  logic [DW-1:0]   word [SNAP_WORDS];
  logic [IDXW-1:0] idx;

  for (genvar w = 0; w < SNAP_WORDS; w++) begin : g_word
    assign word[w] = snap[w*DW +: DW];
  end

  assign idx = IDXW'(addr - AW'(SNAP_BASE));

  always_comb begin
    rdata = '0;
    if (addr == AW'(ADDR_CTL)) begin
      rdata[BIT_STEP] = step_en;
      rdata[BIT_BUSY] = busy;
      rdata[BIT_MASK] = irq_mask;
      rdata[BIT_STOP] = stopped;
    end else if (addr >= AW'(SNAP_BASE)) begin
      rdata = word[idx];
    end
  end
endmodule

// File: rtl/step_dbg_ctrl.sv
`timescale 1ns/1ps
module step_dbg_ctrl
  import step_dbg_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        reg_addr,
  input  logic                 reg_wr,
  input  logic [CTL_WBITS-1:0] reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  input  logic                 ext_dma_req,
  output logic                 cpu_hold_req,
  input  logic                 cpu_hold_ack,
  input  logic                 cpu_fetch,
  input  logic [DW-1:0]        cpu_opcode,
  input  logic [DW-1:0]        cpu_pc,
  input  logic [DW-1:0]        cpu_st,
  input  logic                 vid_irq_in,
  output logic                 cpu_irq_out
);
  logic            ctl_wr;
  logic            step_en;
  logic            irq_mask;
  logic            busy;
  logic            rel_pulse;
  logic            enable_set;
  logic            trig_req;
  logic            stopped;
  logic [DW-1:0]   count;
  logic [4*DW-1:0] snap;

  assign ctl_wr = reg_wr && (reg_addr == AW'(ADDR_CTL));

  step_ctrl_regs u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (reg_wdata),
    .hold_ack   (cpu_hold_ack),
    .cpu_fetch  (cpu_fetch),
    .step_en    (step_en),
    .irq_mask   (irq_mask),
    .busy       (busy),
    .rel_pulse  (rel_pulse),
    .enable_set (enable_set),
    .trig_req   (trig_req)
  );

  step_snapshot #(.DW(DW)) u_snap (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_fetch  (cpu_fetch),
    .cpu_opcode (cpu_opcode),
    .cpu_pc     (cpu_pc),
    .cpu_st     (cpu_st),
    .step_en    (step_en),
    .enable_set (enable_set),
    .count      (count),
    .snap       (snap)
  );

  assign stopped      = step_en & cpu_hold_ack;
  assign cpu_hold_req = step_en ? ~rel_pulse : ext_dma_req;
  assign cpu_irq_out  = vid_irq_in & ~(step_en & irq_mask);

  step_read_mux #(.DW(DW), .AW(AW)) u_rd (
    .addr     (reg_addr),
    .step_en  (step_en),
    .busy     (busy),
    .irq_mask (irq_mask),
    .stopped  (stopped),
    .snap     (snap),
    .rdata    (reg_rdata)
  );
endmodule

// File: rtl/step_dbg_chk.sv
`timescale 1ns/1ps
module step_dbg_chk #(
  parameter int DW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            step_en,
  input logic            irq_mask,
  input logic            busy,
  input logic            rel_pulse,
  input logic            enable_set,
  input logic            trig_req,
  input logic            ext_dma_req,
  input logic            cpu_hold_req,
  input logic            cpu_fetch,
  input logic [DW-1:0]   cpu_opcode,
  input logic [DW-1:0]   cpu_pc,
  input logic [DW-1:0]   cpu_st,
  input logic            cpu_irq_out,
  input logic [DW-1:0]   count,
  input logic [4*DW-1:0] snap
);
  // R2
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |-> (cpu_hold_req == ext_dma_req));

  // R3
  step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !rel_pulse) |-> cpu_hold_req);

  // R4
  release_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_pulse |=> !rel_pulse);

  // R6
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_req && busy) |=> !rel_pulse);

  // R7
  snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_fetch |=> (snap[4*DW-1:DW] == $past({cpu_opcode, cpu_pc, cpu_st})));

  // R8
  count_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && cpu_fetch) |=> (count == DW'($past(count) + 1'b1)));

  // R8
  count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable_set |=> (count == '0));

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && irq_mask) |-> !cpu_irq_out);
endmodule

bind step_dbg_ctrl step_dbg_chk #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .step_en      (step_en),
  .irq_mask     (irq_mask),
  .busy         (busy),
  .rel_pulse    (rel_pulse),
  .enable_set   (enable_set),
  .trig_req     (trig_req),
  .ext_dma_req  (ext_dma_req),
  .cpu_hold_req (cpu_hold_req),
  .cpu_fetch    (cpu_fetch),
  .cpu_opcode   (cpu_opcode),
  .cpu_pc       (cpu_pc),
  .cpu_st       (cpu_st),
  .cpu_irq_out  (cpu_irq_out),
  .count        (count),
  .snap         (snap)
);

// File: tb/step_dbg_ctrl_tb_top.sv
`timescale 1ns/1ps
module step_dbg_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ext_dma_req = 1'b1;
  logic        cpu_hold_req;
  logic        cpu_hold_ack;
  logic        cpu_fetch;
  logic [15:0] cpu_opcode, cpu_pc, cpu_st;
  logic        vid_irq_in = 1'b0;
  logic        cpu_irq_out;

  int checks = 0;
  int fails  = 0;
  int fetch_cnt = 0;
  logic [15:0] rec_op, rec_pc, rec_st;
  logic [15:0] exp_cnt = '0;

  always #5 clk = ~clk;

  step_dbg_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_dma_req(ext_dma_req),
    .cpu_hold_req(cpu_hold_req), .cpu_hold_ack(cpu_hold_ack),
    .cpu_fetch(cpu_fetch), .cpu_opcode(cpu_opcode), .cpu_pc(cpu_pc),
    .cpu_st(cpu_st), .vid_irq_in(vid_irq_in), .cpu_irq_out(cpu_irq_out)
  );

  // ---- stub processor: holds only at instruction boundaries ----
  typedef enum logic [1:0] {S_HELD, S_FETCH, S_EXEC} stub_t;
  stub_t       st_q;
  logic [15:0] pc_q;
  logic [2:0]  ex_q;

  assign cpu_hold_ack = (st_q == S_HELD);
  assign cpu_fetch    = (st_q == S_FETCH);
  assign cpu_pc       = pc_q;
  assign cpu_opcode   = pc_q ^ 16'h2C55;
  assign cpu_st       = {pc_q[7:0], 8'h5A};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_EXEC;
      pc_q <= 16'h0100;
      ex_q <= 3'd1;
    end else begin
      case (st_q)
        S_HELD:  if (!cpu_hold_req) st_q <= S_FETCH;
        S_FETCH: begin
          ex_q <= 3'd1 + {1'b0, pc_q[2:1]};
          pc_q <= pc_q + 16'd2;
          st_q <= S_EXEC;
        end
        default: begin
          if (ex_q == 3'd1) st_q <= cpu_hold_req ? S_HELD : S_FETCH;
          else              ex_q <= ex_q - 3'd1;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && cpu_fetch) begin
      fetch_cnt++;
      rec_op = cpu_opcode;
      rec_pc = cpu_pc;
      rec_st = cpu_st;
    end
  end

  // ---- helpers ----
  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input bit step, input bit trig, input bit mask);
    @(negedge clk);
    reg_addr = 3'd0; reg_wdata = {mask, trig, step}; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd_now(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_stopped();
    logic [15:0] d = '0;
    for (int i = 0; i < 60; i++) begin
      rd(3'd0, d);
      if (d[3]) break;
    end
    chk(d[3] == 1'b1, "R9 stopped", d[3], 1);
  endtask

  task automatic check_snap(input string req);
    logic [15:0] d;
    rd(3'd7, d); chk(d == rec_op, {req, " opcode"}, d, rec_op);
    rd(3'd6, d); chk(d == rec_pc, {req, " pc"}, d, rec_pc);
    rd(3'd5, d); chk(d == rec_st, {req, " st"}, d, rec_st);
    rd(3'd4, d); chk(d == exp_cnt, "R8 count", d, exp_cnt);
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    logic [15:0] d;
    rd(3'd0, d); chk(d == 16'h0, "R1 control", d, 0);
    for (int a = 4; a < 8; a++) begin
      rd(3'(a), d); chk(d == 16'h0, "R1 snapshot", d, 0);
    end
    chk(fetch_cnt == 0, "R2 held by dma", fetch_cnt, 0);
  endtask

  task automatic t_passthrough();
    int f0;
    logic [15:0] d;
    @(negedge clk); chk(cpu_hold_req == 1'b1, "R2 dma high", cpu_hold_req, 1);
    ext_dma_req = 1'b0;
    #1 chk(cpu_hold_req == 1'b0, "R2 dma low", cpu_hold_req, 0);
    f0 = fetch_cnt;
    repeat (40) @(negedge clk);
    chk(fetch_cnt > f0, "R2 free run", fetch_cnt - f0, 1);
    rd(3'd4, d); chk(d == 16'h0, "R8 no count when off", d, 0);
  endtask

  task automatic t_enable_on_fetch();
    int f0;
    logic [15:0] eop, epc, est;
    @(negedge clk);
    while (!cpu_fetch) @(negedge clk);
    eop = cpu_opcode; epc = cpu_pc; est = cpu_st;
    reg_addr = 3'd0; reg_wdata = 3'b001; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    f0 = fetch_cnt;
    wait_stopped();
    chk(fetch_cnt == f0, "R3 parks after enable", fetch_cnt - f0, 0);
    exp_cnt = '0;
    rec_op = eop; rec_pc = epc; rec_st = est;
    check_snap("R7 coincident");
  endtask

  task automatic t_step_hold();
    int f0 = fetch_cnt;
    repeat (20) begin
      @(negedge clk);
      chk(cpu_hold_req == 1'b1, "R3 hold", cpu_hold_req, 1);
    end
    chk(fetch_cnt == f0, "R3 no fetch", fetch_cnt - f0, 0);
  endtask

  task automatic t_single_step();
    int f0 = fetch_cnt;
    logic [15:0] d;
    wr_ctl(1'b1, 1'b1, 1'b0);
    chk(cpu_hold_req == 1'b0, "R4 release", cpu_hold_req, 0);
    @(negedge clk);
    chk(cpu_hold_req == 1'b1, "R4 one cycle", cpu_hold_req, 1);
    rd_now(3'd0, d);
    chk(d[3] == 1'b0, "R9 running", d[3], 0);
    chk(d[1] == 1'b1, "R4 pending", d[1], 1);
    wait_stopped();
    chk(fetch_cnt - f0 == 1, "R5 one fetch", fetch_cnt - f0, 1);
    rd(3'd0, d);
    chk(d[1] == 1'b0, "R4 pending clear", d[1], 0);
    exp_cnt++;
    check_snap("R7 step");
    rd(3'd2, d); chk(d == 16'h0, "R7 unmapped", d, 0);
  endtask

  task automatic t_double_trigger();
    int f0 = fetch_cnt;
    @(negedge clk);
    reg_addr = 3'd0; reg_wdata = 3'b011; reg_wr = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    wait_stopped();
    chk(fetch_cnt - f0 == 1, "R6 double trigger", fetch_cnt - f0, 1);
    exp_cnt++;
    check_snap("R7 double");
  endtask

  task automatic t_trigger_while_running();
    int f0 = fetch_cnt;
    wr_ctl(1'b1, 1'b1, 1'b0);
    while (!cpu_fetch) @(negedge clk);
    @(negedge clk);
    reg_addr = 3'd0; reg_wdata = 3'b011; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    wait_stopped();
    chk(fetch_cnt - f0 == 1, "R6 trigger while running", fetch_cnt - f0, 1);
    exp_cnt++;
    check_snap("R7 running");
  endtask

  task automatic t_irq_mask();
    logic [15:0] d;
    vid_irq_in = 1'b1;
    wr_ctl(1'b1, 1'b0, 1'b1);
    chk(cpu_irq_out == 1'b0, "R10 masked", cpu_irq_out, 0);
    rd(3'd4, d); chk(d == exp_cnt, "R8 rewrite keeps count", d, exp_cnt);
    wr_ctl(1'b1, 1'b0, 1'b0);
    chk(cpu_irq_out == 1'b1, "R10 unmasked", cpu_irq_out, 1);
    ext_dma_req = 1'b1;
    wr_ctl(1'b0, 1'b0, 1'b1);
    chk(cpu_irq_out == 1'b1, "R10 mask without step", cpu_irq_out, 1);
    chk(cpu_hold_req == 1'b1, "R2 back to dma", cpu_hold_req, 1);
    vid_irq_in = 1'b0;
    #1 chk(cpu_irq_out == 1'b0, "R10 follows input", cpu_irq_out, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_passthrough();
    t_enable_on_fetch();
    t_step_hold();
    for (int i = 0; i < 6; i++) t_single_step();
    t_double_trigger();
    t_trigger_while_running();
    t_single_step();
    t_irq_mask();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule